// File: doc/BRIEF.md
# Dual Timer/Counter Pair

Two independent 8+8-bit count units that sit beside a small processor core. Each unit has a low byte and a high byte. A two-bit mode selects how the bytes are chained: a 13-bit count, a full 16-bit count, an 8-bit count that reloads from the high byte, or a split mode. In split mode unit 0 counts on its low byte only and unit 1 freezes. Each unit advances either on the machine-cycle strobe (timer function) or on falling edges seen on its count pin (counter function). A run bit enables the unit. A gate bit can also make counting depend on a level pin. When a unit rolls over it raises a sticky overflow flag. That flag drops when the interrupt controller acknowledges it.

Software loads either byte through per-unit write strobes that share one data bus. The mode, run, gate and function-select controls arrive as static configuration inputs. They are decoded from a control register outside this block.

Top module: `tmr_pair`

## Requirements
- R1: After reset deasserts, every low byte, high byte and overflow flag reads zero.
- R2: Mode code 2'b00 counts a 13-bit value formed from the high byte (upper 8 bits) and bits [4:0] of the low byte. Bits [7:5] of the low byte are untouched by counting. Stepping past 13'h1FFF wraps to zero and is an overflow.
- R3: Mode code 2'b01 counts the high byte and low byte as one 16-bit value. Stepping past 16'hFFFF wraps to zero and is an overflow.
- R4: Mode code 2'b10 increments the low byte only. When the low byte steps from 8'hFF, it is loaded with the high byte instead, and this is an overflow. The high byte never changes by counting.
- R5: Mode code 2'b11 makes unit 0 count on its low byte alone, with 8-bit wrap as its overflow, and keeps its high byte fixed. In the same mode, unit 1 holds both bytes and never overflows.
- R6: With function select 0 (timer), an enabled unit steps exactly once for each clock on which the machine-cycle strobe is high.
- R7: With function select 1 (counter), the count pin passes through a two-flop synchronizer and is sampled on each strobe. A unit steps on a strobe whose sample is 0 when the previous strobe's sample was 1.
- R8: A unit steps only while its run bit is 1 and either its gate bit is 0 or its gate pin is 1. Otherwise both bytes hold.
- R9: The overflow flag is set on the clock after an overflow and is cleared on the clock after an acknowledge. An overflow in the same cycle as the acknowledge leaves the flag set.
- R10: A byte write is visible on the next clock. Any write to a unit cancels that unit's step in the same cycle, including its overflow. The unwritten byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle strobe, one clock wide |
| mode_i | input | 2*UNITS | Mode code per unit, unit u at [2u+1:2u] |
| run_i | input | UNITS | Run enable per unit |
| gate_i | input | UNITS | Gate-by-pin enable per unit |
| gate_pin_i | input | UNITS | Gate level pin per unit |
| cnt_sel_i | input | UNITS | 0 = timer function, 1 = counter function |
| cnt_pin_i | input | UNITS | Count pin per unit (asynchronous) |
| wr_lo_i | input | UNITS | Low-byte write strobe per unit |
| wr_hi_i | input | UNITS | High-byte write strobe per unit |
| wr_data_i | input | BYTE_W | Write data shared by all strobes |
| ack_i | input | UNITS | Interrupt acknowledge per unit |
| lo_o | output | UNITS*BYTE_W | Low bytes, unit u at [8u+7:8u] |
| hi_o | output | UNITS*BYTE_W | High bytes, unit u at [8u+7:8u] |
| flag_o | output | UNITS | Overflow flags |

## Verification
The assertions assume that the gate pins, write strobes, acknowledges and configuration are synchronous to the clock. They also assume the strobe is a single-clock pulse. Only the count pins may change freely, because they are synchronized. The stimulus drives every input from one process on the falling edge. It changes the count pins at arbitrary cycles, but only moves the gate pins between clocks. This keeps the stimulus inside those assumptions while still reaching writes that collide with steps, and acknowledges that collide with overflows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic ev_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      if (tick_i) last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // high sample on previous strobe, low sample on this one
  assign ev_o = tick_i & last_q & ~sync_q[SYNC_STAGES-1];

  // a low sample cannot be followed directly by an event
  assert_no_back_to_back_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !sync_q[SYNC_STAGES-1]) |=> !ev_o);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int LOW13_W       = 5,
  parameter bit HALT_IN_SPLIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              run_i,
  input  logic              gate_i,
  input  logic              gate_pin_i,
  input  logic              cnt_sel_i,
  input  logic              tick_i,
  input  logic              ev_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ack_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              flag_o
);
  localparam int MID_W  = BYTE_W + LOW13_W;
  localparam int WIDE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic              flag_q, roll, enable, step, wr_any, inc;
  logic [BYTE_W:0]   byte_sum;
  logic [MID_W:0]    mid_sum;
  logic [WIDE_W:0]   wide_sum;
  logic [BYTE_W-1:0] split_lo;
  logic              split_roll;

  assign enable = run_i & (~gate_i | gate_pin_i);
  assign step   = cnt_sel_i ? ev_i : tick_i;
  assign wr_any = wr_lo_i | wr_hi_i;
  assign inc    = enable & step & ~wr_any;

  assign byte_sum = {1'b0, lo_q} + {{BYTE_W{1'b0}}, 1'b1};
  assign mid_sum  = {1'b0, hi_q, lo_q[LOW13_W-1:0]} + {{MID_W{1'b0}}, 1'b1};
  assign wide_sum = {1'b0, hi_q, lo_q} + {{WIDE_W{1'b0}}, 1'b1};

  generate
    if (HALT_IN_SPLIT) begin : g_halt
      assign split_lo   = lo_q;
      assign split_roll = 1'b0;
    end else begin : g_run
      assign split_lo   = byte_sum[BYTE_W-1:0];
      assign split_roll = byte_sum[BYTE_W];
    end
  endgenerate

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    roll = 1'b0;
    unique case (mode_i)
      MODE_13: begin
        lo_n = {lo_q[BYTE_W-1:LOW13_W], mid_sum[LOW13_W-1:0]};
        hi_n = mid_sum[MID_W-1:LOW13_W];
        roll = mid_sum[MID_W];
      end
      MODE_16: begin
        lo_n = wide_sum[BYTE_W-1:0];
        hi_n = wide_sum[WIDE_W-1:BYTE_W];
        roll = wide_sum[WIDE_W];
      end
      MODE_RELOAD: begin
        roll = byte_sum[BYTE_W];
        lo_n = roll ? hi_q : byte_sum[BYTE_W-1:0];
      end
      MODE_SPLIT: begin
        lo_n = split_lo;
        roll = split_roll;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_lo_i)  lo_q <= wr_data_i;
      else if (inc) lo_q <= lo_n;
      if (wr_hi_i)  hi_q <= wr_data_i;
      else if (inc) hi_q <= hi_n;
      if (inc && roll) flag_q <= 1'b1;
      else if (ack_i)  flag_q <= 1'b0;
    end
  end

  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign flag_o = flag_q;

  assert_hold_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable && !wr_any) |=> ($stable(lo_q) && $stable(hi_q)));

  assert_timer_needs_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_sel_i && !tick_i && !wr_any) |=> ($stable(lo_q) && $stable(hi_q)));

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RELOAD && inc && lo_q == {BYTE_W{1'b1}}) |=> (lo_q == $past(hi_q)));

  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !inc) |=> !flag_q);

  assert_write_lo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (lo_q == $past(wr_data_i)));

  assert_write_hi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (hi_q == $past(wr_data_i)));

  generate
    if (HALT_IN_SPLIT) begin : g_halt_chk
      assert_split_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MODE_SPLIT && !wr_any && !flag_q) |=>
          ($stable(lo_q) && $stable(hi_q) && !flag_q));
    end
  endgenerate
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int UNITS   = 2,
  parameter int BYTE_W  = 8,
  parameter int LOW13_W = 5,
  parameter int HALT_ID = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [2*UNITS-1:0]      mode_i,
  input  logic [UNITS-1:0]        run_i,
  input  logic [UNITS-1:0]        gate_i,
  input  logic [UNITS-1:0]        gate_pin_i,
  input  logic [UNITS-1:0]        cnt_sel_i,
  input  logic [UNITS-1:0]        cnt_pin_i,
  input  logic [UNITS-1:0]        wr_lo_i,
  input  logic [UNITS-1:0]        wr_hi_i,
  input  logic [BYTE_W-1:0]       wr_data_i,
  input  logic [UNITS-1:0]        ack_i,
  output logic [UNITS*BYTE_W-1:0] lo_o,
  output logic [UNITS*BYTE_W-1:0] hi_o,
  output logic [UNITS-1:0]        flag_o
);
  logic [UNITS-1:0] ev;

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    tmr_edge_det #(.SYNC_STAGES(2)) i_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .pin_i  (cnt_pin_i[g]),
      .ev_o   (ev[g])
    );

    tmr_unit #(
      .BYTE_W       (BYTE_W),
      .LOW13_W      (LOW13_W),
      .HALT_IN_SPLIT(g == HALT_ID)
    ) i_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (tmr_mode_e'(mode_i[2*g+:2])),
      .run_i      (run_i[g]),
      .gate_i     (gate_i[g]),
      .gate_pin_i (gate_pin_i[g]),
      .cnt_sel_i  (cnt_sel_i[g]),
      .tick_i     (tick_i),
      .ev_i       (ev[g]),
      .wr_lo_i    (wr_lo_i[g]),
      .wr_hi_i    (wr_hi_i[g]),
      .wr_data_i  (wr_data_i),
      .ack_i      (ack_i[g]),
      .lo_o       (lo_o[g*BYTE_W+:BYTE_W]),
      .hi_o       (hi_o[g*BYTE_W+:BYTE_W]),
      .flag_o     (flag_o[g])
    );
  end
endmodule

// File: tb/test_tmr_pair.sv
`timescale 1ns/1ps
module test_tmr_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] mode = '0;
  logic [1:0] run = '0, gate = '0, gpin = '0, csel = '0, cpin = '0;
  logic [1:0] wlo = '0, whi = '0, ack = '0;
  logic [7:0] wdata = '0;
  logic [15:0] lo_o, hi_o;
  logic [1:0] flag_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  tmr_pair i_tmr_pair (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode), .run_i(run),
    .gate_i(gate), .gate_pin_i(gpin), .cnt_sel_i(csel), .cnt_pin_i(cpin),
    .wr_lo_i(wlo), .wr_hi_i(whi), .wr_data_i(wdata), .ack_i(ack),
    .lo_o(lo_o), .hi_o(hi_o), .flag_o(flag_o)
  );

  // behavioural reference
  logic [7:0] m_lo [2];
  logic [7:0] m_hi [2];
  logic       m_fl [2];
  logic       m_s1 [2], m_s2 [2], m_last [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < 2; u++) begin
        m_lo[u] = 0; m_hi[u] = 0; m_fl[u] = 0;
        m_s1[u] = 0; m_s2[u] = 0; m_last[u] = 0;
      end
    end else begin
      for (int u = 0; u < 2; u++) begin
        bit ev, go, rolled;
        int v;
        logic [7:0] nl, nh;
        ev = tick && m_last[u] && !m_s2[u];
        if (tick) m_last[u] = m_s2[u];
        m_s2[u] = m_s1[u];
        m_s1[u] = cpin[u];
        go = run[u] && (!gate[u] || gpin[u]) && (csel[u] ? ev : tick) && !wlo[u] && !whi[u];
        rolled = 0; nl = m_lo[u]; nh = m_hi[u];
        if (go) begin
          case (mode[2*u+:2])
            2'b00: begin
              v = m_hi[u] * 32 + m_lo[u][4:0];
              if (v == 8191) begin rolled = 1; v = 0; end else v = v + 1;
              nh = 8'(v / 32);
              nl = {m_lo[u][7:5], 5'(v % 32)};
            end
            2'b01: begin
              v = m_hi[u] * 256 + m_lo[u];
              if (v == 65535) begin rolled = 1; v = 0; end else v = v + 1;
              nh = 8'(v / 256); nl = 8'(v % 256);
            end
            2'b10: begin
              if (m_lo[u] == 8'hFF) begin rolled = 1; nl = m_hi[u]; end
              else nl = m_lo[u] + 8'd1;
            end
            default: begin
              if (u == 0) begin
                if (m_lo[u] == 8'hFF) rolled = 1;
                nl = m_lo[u] + 8'd1;
              end
            end
          endcase
        end
        if (wlo[u]) nl = wdata;
        if (whi[u]) nh = wdata;
        m_lo[u] = nl; m_hi[u] = nh;
        if (rolled) m_fl[u] = 1;
        else if (ack[u]) m_fl[u] = 0;
      end
    end
  end

  task automatic compare();
    for (int u = 0; u < 2; u++) begin
      checks++;
      if (lo_o[u*8+:8] !== m_lo[u] || hi_o[u*8+:8] !== m_hi[u] || flag_o[u] !== m_fl[u]) begin
        errors++;
        $display("FAIL %s unit %0d lo/hi/flag act %h/%h/%b exp %h/%h/%b", tag, u,
                 lo_o[u*8+:8], hi_o[u*8+:8], flag_o[u], m_lo[u], m_hi[u], m_fl[u]);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic write(input int u, input bit hi, input logic [7:0] d);
    wdata = d;
    if (hi) whi[u] = 1'b1; else wlo[u] = 1'b1;
    step();
    wlo = '0; whi = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog act hung exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (lo_o !== 16'h0 || hi_o !== 16'h0 || flag_o !== 2'b00) begin
      errors++;
      $display("FAIL R1 reset act %h/%h/%b exp 0000/0000/00", lo_o, hi_o, flag_o);
    end
    compare();

    // R3 on unit 0, R2 on unit 1 near rollover
    tag = "R3";
    mode = 4'b00_01;
    write(0, 0, 8'hFE); write(0, 1, 8'hFF);
    write(1, 1, 8'hFF); write(1, 0, 8'hFD);
    run = 2'b11; tick = 1'b1;
    tag = "R2";
    repeat (12) step();

    // R10: writes colliding with steps
    tag = "R10";
    write(0, 0, 8'h10);
    write(1, 1, 8'h22);
    wlo = 2'b11; whi = 2'b01; wdata = 8'hFF; step(); wlo = '0; whi = '0;
    repeat (4) step();

    // R4 with R6: reload, strobe every other clock
    tag = "R4";
    mode = 4'b10_10;
    write(0, 1, 8'hF0); write(0, 0, 8'hFA);
    write(1, 1, 8'h7E); write(1, 0, 8'hFC);
    for (int i = 0; i < 80; i++) begin tick = i[0]; step(); end
    tag = "R6";
    for (int i = 0; i < 200; i++) begin tick = ($urandom_range(0, 2) == 0); step(); end

    // R5: split mode
    tag = "R5";
    mode = 4'b11_11; tick = 1'b1;
    write(1, 0, 8'h44); write(1, 1, 8'h55);
    for (int i = 0; i < 600; i++) begin ack = (i % 97 == 5) ? 2'b11 : 2'b00; step(); end
    ack = '0;

    // R7: counter function with asynchronous pin activity
    tag = "R7";
    mode = 4'b10_01; csel = 2'b11;
    write(1, 1, 8'hFD); write(1, 0, 8'hF8);
    for (int i = 0; i < 1500; i++) begin
      tick = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 2) == 0) cpin = 2'($urandom);
      step();
    end

    // R8: gating by run bit and gate pin
    tag = "R8";
    csel = 2'b00; gate = 2'b11; mode = 4'b00_01; tick = 1'b1;
    for (int i = 0; i < 800; i++) begin
      gpin = 2'($urandom);
      run = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b11;
      if (i == 400) gate = 2'b01;
      step();
    end

    // R9: overflows against acknowledges
    tag = "R9";
    gate = '0; run = 2'b11; mode = 4'b10_10;
    write(0, 1, 8'hFC); write(1, 1, 8'hFE);
    for (int i = 0; i < 800; i++) begin
      tick = ($urandom_range(0, 3) != 0);
      ack = 2'($urandom);
      step();
    end

    // mixed traffic, all functions
    tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin mode = 4'($urandom); csel = 2'($urandom); gate = 2'($urandom); end
      tick = ($urandom_range(0, 1) == 1);
      cpin = 2'($urandom);
      gpin = ($urandom_range(0, 3) == 0) ? 2'($urandom) : gpin;
      run = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b11;
      ack = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00;
      wdata = 8'($urandom);
      wlo = ($urandom_range(0, 30) == 0) ? 2'($urandom) : 2'b00;
      whi = ($urandom_range(0, 30) == 0) ? 2'($urandom) : 2'b00;
      step();
    end
    wlo = '0; whi = '0; ack = '0;
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule